// File: doc/BRIEF.md
# Receive-Only Two-Wire Slave Front End

This block is the bus-facing half of a display controller's serial port. It watches an already-synchronized two-wire bus (SCL and SDA) and recognizes the start and stop conditions. It accepts only write transfers aimed at its own address, which is a six-bit constant followed by one bit taken from a board strap. Several identical devices can share the bus. Every device whose strap matches acknowledges the same address byte together, and all other devices stay silent until the next start condition.

Once the block is addressed, it shifts in each following byte and hands it downstream as a one-cycle strobe with the byte value. A flag marks the first byte after the address. For each data byte, the downstream logic decides whether it is acknowledged by holding `ack_req`. When the downstream store cannot keep up, it raises `busy`. The block then holds SCL low after the acknowledge bit until `busy` clears, which slows the master down without losing any data. A one-cycle pulse marks the stop condition that closes a selected transfer. The block never transmits data. The only things it drives are the acknowledge bit on SDA and the clock hold on SCL, and both are open-drain pull-low requests.

Top module: `disp_i2c_rx`

## Requirements
- R1: A stop condition (SDA rising while SCL is high) that closes a transfer whose address was acknowledged produces exactly one single-cycle `xfer_end` pulse. A stop after an unacknowledged address produces none.
- R2: After a start condition (SDA falling while SCL is high), an address byte equal to binary 011111 followed by the `addr_strap` level, with bit 0 (R/W) equal to 0, is acknowledged. The block pulls SDA low for the whole ninth SCL high period.
- R3: An address byte whose upper six bits or strapped bit differ is not acknowledged. Every remaining byte of that transfer then produces no `byte_valid` and no acknowledge, whatever `ack_req` is.
- R4: An address byte whose R/W bit is 1 is treated as a mismatch and is not acknowledged.
- R5: Each data byte of a selected transfer, received MSB first, produces one single-cycle `byte_valid` pulse with `byte_data` equal to the received value.
- R6: `first_byte` is 1 together with `byte_valid` on the first data byte after the address, and 0 on the later bytes of that transfer.
- R7: A data byte is acknowledged only if `ack_req` is 1 at the SCL falling edge that ends its eighth bit. `sda_pull` is released on the SCL falling edge that ends the acknowledge bit.
- R8: If `busy` is 1 at the SCL falling edge that ends an acknowledge bit, `scl_pull` holds SCL low until `busy` is 0. It is released within two cycles after that, and the bytes that follow are received unchanged.
- R9: A start or stop condition in the middle of a byte discards the partial byte. After a repeated start, the block evaluates a fresh address byte, and the next full data byte is again flagged as first.
- R10: After reset, `sda_pull`, `scl_pull`, `byte_valid`, `first_byte` and `xfer_end` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Synchronized SCL bus level |
| sda_in | input | 1 | Synchronized SDA bus level |
| addr_strap | input | 1 | Level that sets the address LSB |
| ack_req | input | 1 | Downstream asks for the current data byte to be acknowledged |
| busy | input | 1 | Downstream store cannot accept another byte yet |
| sda_pull | output | 1 | Pull SDA low (acknowledge) |
| scl_pull | output | 1 | Pull SCL low (clock stretch) |
| byte_valid | output | 1 | One-cycle strobe for a received data byte |
| byte_data | output | 8 | Received data byte |
| first_byte | output | 1 | Byte is the first after the address |
| xfer_end | output | 1 | One-cycle pulse at the stop that closes a selected transfer |

## Verification
The hardest cases to reach are the clock stretch and the aborted byte. Both need the bench master to model an open-drain bus, where the SCL and SDA levels the block sees are the AND of the master's drive and the block's own pull requests. For the stretch, `busy` is raised before a byte. A watcher process waits for `scl_pull`, checks that SCL stays low while the master has already released it, and then clears `busy`. The bytes that follow must still match the scoreboard. For the abort, the master sends four bits of a byte, then issues a repeated start or a stop. The check is that no strobe appears for the partial byte and that the next byte is flagged as first.

// File: rtl/disp_i2c_rx_pkg.sv
package disp_i2c_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_ACK,
    ST_SKIP
  } rx_state_e;
endpackage

// File: rtl/bus_cond_detect.sv
module bus_cond_detect (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_prev, sda_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_lvl  <= 1'b1;
      sda_lvl  <= 1'b1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_lvl  <= scl_in;
      sda_lvl  <= sda_in;
      scl_prev <= scl_lvl;
      sda_prev <= sda_lvl;
    end
  end

  assign scl_rise = scl_lvl & ~scl_prev;
  assign scl_fall = ~scl_lvl & scl_prev;
  assign start_ev = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_ev  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/rx_shifter.sv
module rx_shifter #(
  parameter int BYTE_W = 8,
  localparam int CW = $clog2(BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [BYTE_W-1:0] data,
  output logic              full,
  output logic              last_shift
);
  logic [CW-1:0] count;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
      data  <= '0;
    end else if (shift_en && !full) begin
      count <= count + 1'b1;
      data  <= {data[BYTE_W-2:0], bit_in};
    end
  end

  assign full       = (count == CW'(BYTE_W));
  assign last_shift = shift_en && (count == CW'(BYTE_W - 1));
endmodule

// File: rtl/disp_i2c_rx.sv
module disp_i2c_rx
  import disp_i2c_rx_pkg::*;
#(
  parameter int          BYTE_W      = 8,
  parameter int          PREFIX_W    = 6,
  parameter logic [5:0]  ADDR_PREFIX = 6'b011111
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              addr_strap,
  input  logic              ack_req,
  input  logic              busy,
  output logic              sda_pull,
  output logic              scl_pull,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_data,
  output logic              first_byte,
  output logic              xfer_end
);
  localparam int ADDR_W = PREFIX_W + 1;

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
  logic sh_clr, sh_en, sh_full, sh_last;
  logic [BYTE_W-1:0] sh_data;
  rx_state_e state;
  logic selected, first_pend, addr_hit;

  bus_cond_detect u_cond (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev)
  );

  assign sh_en  = scl_rise && (state == ST_ADDR || state == ST_DATA);
  assign sh_clr = start_ev || stop_ev || (scl_fall && state == ST_ACK);

  rx_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk(clk), .rst(rst), .clr(sh_clr), .shift_en(sh_en), .bit_in(sda_lvl),
    .data(sh_data), .full(sh_full), .last_shift(sh_last)
  );

  // Address byte: prefix, strapped bit, then R/W which must be write (0)
  assign addr_hit = (sh_data[BYTE_W-1 -: ADDR_W] == {ADDR_PREFIX[PREFIX_W-1:0], addr_strap})
                    && !sh_data[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      selected   <= 1'b0;
      first_pend <= 1'b0;
      sda_pull   <= 1'b0;
      scl_pull   <= 1'b0;
      byte_valid <= 1'b0;
      byte_data  <= '0;
      first_byte <= 1'b0;
      xfer_end   <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      xfer_end   <= 1'b0;
      if (scl_pull && !busy) scl_pull <= 1'b0;
      if (stop_ev) begin
        state    <= ST_IDLE;
        sda_pull <= 1'b0;
        scl_pull <= 1'b0;
        xfer_end <= selected;
        selected <= 1'b0;
      end else if (start_ev) begin
        state      <= ST_ADDR;
        sda_pull   <= 1'b0;
        scl_pull   <= 1'b0;
        selected   <= 1'b0;
        first_pend <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR: begin
            if (scl_fall && sh_full) begin
              if (addr_hit) begin
                state      <= ST_ACK;
                sda_pull   <= 1'b1;
                selected   <= 1'b1;
                first_pend <= 1'b1;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          ST_DATA: begin
            if (sh_last) begin
              byte_valid <= 1'b1;
              byte_data  <= {sh_data[BYTE_W-2:0], sda_lvl};
              first_byte <= first_pend;
              first_pend <= 1'b0;
            end
            if (scl_fall && sh_full) begin
              state    <= ST_ACK;
              sda_pull <= ack_req;
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              state    <= ST_DATA;
              sda_pull <= 1'b0;
              scl_pull <= busy;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // ---------------- assertions ----------------
  assert_ack_starts_low_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull) |-> !scl_lvl);
  assert_ack_release_R7: assert property (@(posedge clk) disable iff (rst)
    (sda_pull && scl_fall && !start_ev && !stop_ev) |=> !sda_pull);
  assert_skip_silent_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SKIP) |-> (!sda_pull && !byte_valid));
  assert_stretch_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_pull) |-> $past(busy));
  assert_stretch_release_R8: assert property (@(posedge clk) disable iff (rst)
    (scl_pull && !busy) |=> !scl_pull);
  assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    byte_valid |=> !byte_valid);
  assert_end_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    xfer_end |=> !xfer_end);
endmodule

// File: tb/sim_disp_i2c_rx.sv
module sim_disp_i2c_rx;
  localparam int H = 6;
  logic clk = 1'b0, rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic addr_strap = 1'b0, ack_req = 1'b1, busy = 1'b0;
  logic sda_pull, scl_pull, byte_valid, first_byte, xfer_end;
  logic [7:0] byte_data;
  wire scl_bus = scl_m & ~scl_pull;
  wire sda_bus = sda_m & ~sda_pull;
  int checks = 0, errors = 0, ends = 0;
  bit done = 1'b0;
  logic [8:0] exp_q[$];

  always #10 clk = ~clk;

  disp_i2c_rx u0 (
    .clk(clk), .rst(rst), .scl_in(scl_bus), .sda_in(sda_bus),
    .addr_strap(addr_strap), .ack_req(ack_req), .busy(busy),
    .sda_pull(sda_pull), .scl_pull(scl_pull), .byte_valid(byte_valid),
    .byte_data(byte_data), .first_byte(first_byte), .xfer_end(xfer_end)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && byte_valid) begin
      if (exp_q.size() == 0) begin
        check(0, "R3 R9 unexpected byte", {first_byte, byte_data}, 0);
      end else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        check({first_byte, byte_data} == e, "R5 R6 byte/first", {first_byte, byte_data}, e);
      end
    end
    if (!rst && xfer_end) ends++;
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bit(input logic b, output logic s);
    sda_m = b;
    wait_clk(H);
    scl_m = 1'b1;
    do @(negedge clk); while (!scl_bus);
    wait_clk(H / 2);
    s = sda_bus;
    wait_clk(H / 2);
    scl_m = 1'b0;
    wait_clk(H);
  endtask

  task automatic do_start();
    sda_m = 1'b1; wait_clk(H);
    scl_m = 1'b1; wait_clk(H);
    sda_m = 1'b0; wait_clk(H);
    scl_m = 1'b0; wait_clk(H);
  endtask

  task automatic do_stop();
    sda_m = 1'b0; wait_clk(H);
    scl_m = 1'b1;
    do @(negedge clk); while (!scl_bus);
    wait_clk(H);
    sda_m = 1'b1; wait_clk(H);
  endtask

  task automatic send_byte(input logic [7:0] v, input bit exp_ack, input bit exp_valid,
                           input bit exp_first, input string tag);
    logic s;
    if (exp_valid) exp_q.push_back({exp_first, v});
    for (int i = 7; i >= 0; i--) put_bit(v[i], s);
    put_bit(1'b1, s);
    check(s == !exp_ack, tag, s, !exp_ack);
  endtask

  task automatic send_bits(input logic [7:0] v, input int n);
    logic s;
    for (int i = 7; i > 7 - n; i--) put_bit(v[i], s);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog timeout");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_clk(4);
    check({sda_pull, scl_pull, byte_valid, first_byte, xfer_end} == 5'b0,
          "R10 reset outputs", {sda_pull, scl_pull, byte_valid, first_byte, xfer_end}, 0);
    rst = 1'b0;
    wait_clk(4);

    // R2 R5 R6 R1: basic write with three bytes
    do_start();
    send_byte(8'h7C, 1, 0, 0, "R2 address ack");
    send_byte(8'hA5, 1, 1, 1, "R5 data ack");
    send_byte(8'h3C, 1, 1, 0, "R6 second byte");
    send_byte(8'h01, 1, 1, 0, "R5 third byte");
    do_stop();
    wait_clk(4);
    check(ends == 1, "R1 end pulse after stop", ends, 1);

    // R3: wrong strapped bit, then wrong prefix; data ignored
    do_start();
    send_byte(8'h7E, 0, 0, 0, "R3 strap mismatch nack");
    send_byte(8'h55, 0, 0, 0, "R3 ignored data no ack");
    do_stop();
    do_start();
    send_byte(8'h5C, 0, 0, 0, "R3 prefix mismatch nack");
    send_byte(8'hFF, 0, 0, 0, "R3 ignored data no ack");
    do_stop();
    wait_clk(4);
    check(ends == 1, "R1 no end pulse after mismatch", ends, 1);

    // R4: read request
    do_start();
    send_byte(8'h7D, 0, 0, 0, "R4 read request nack");
    do_stop();

    // strap high now selects 0x7E
    addr_strap = 1'b1;
    do_start();
    send_byte(8'h7E, 1, 0, 0, "R2 strap high address ack");
    // R7: ack_req low leaves byte unacknowledged but still delivered
    ack_req = 1'b0;
    send_byte(8'h96, 0, 1, 1, "R7 nack when ack_req low");
    check(sda_pull == 1'b0, "R7 sda released", sda_pull, 0);
    ack_req = 1'b1;
    send_byte(8'h69, 1, 1, 0, "R7 ack when ack_req high");
    check(sda_pull == 1'b0, "R7 sda released after ack", sda_pull, 0);
    do_stop();
    addr_strap = 1'b0;

    // R8: clock stretch while busy
    do_start();
    send_byte(8'h7C, 1, 0, 0, "R2 address ack");
    busy = 1'b1;
    fork
      begin
        send_byte(8'hC3, 1, 1, 1, "R8 byte before stretch");
        send_byte(8'h5A, 1, 1, 0, "R8 byte after stretch");
      end
      begin
        while (!scl_pull) @(negedge clk);
        wait_clk(30);
        check(scl_bus == 1'b0 && scl_m == 1'b1, "R8 scl held low", scl_bus, 0);
        busy = 1'b0;
        wait_clk(3);
        check(scl_pull == 1'b0, "R8 scl released", scl_pull, 0);
      end
    join
    do_stop();

    // R9: partial byte then repeated start; partial byte then stop
    do_start();
    send_byte(8'h7C, 1, 0, 0, "R2 address ack");
    send_bits(8'hF0, 4);
    do_start();
    send_byte(8'h7C, 1, 0, 0, "R9 re-address after repeated start");
    send_byte(8'h24, 1, 1, 1, "R9 first flag after repeated start");
    send_bits(8'hAA, 4);
    do_stop();
    wait_clk(10);
    check(exp_q.size() == 0, "R5 R9 all expected bytes seen", exp_q.size(), 0);
    check(ends == 4, "R1 end pulse count", ends, 4);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule